// File: doc/BRIEF.md
# Owner-Side Shared Intervention Responder

This block lives at a caching node of a directory-coherent system. When the home directory finds that this node owns a line and another node wants to read it, home forwards a shared intervention here. The intervention names the line, the node that asked for it and the home node. The responder looks up its own copy of the line. It then sends one message to the requester and one to home, and downgrades the line to Shared.

The messages depend on the line's local state. A dirty (Modified) line sends its data straight to the requester and a sharing writeback with the same data to home. A clean-Exclusive line sends a completion without data to both parties, because home has already sent the requester a speculative copy of the memory data. A line that is no longer held (Shared or Invalid, for example after a silent drop) also sends data-less completions to both parties and keeps its state.

The block services one intervention at a time. A new one is taken only after both outgoing messages have been accepted. A preload port writes line states and data into the local array, so that every case can be set up.

Top module: `ivn_responder`

## Requirements
- R1: For a line in state Modified (encoding 3), the requester port emits kind 1 (data reply) carrying the line's stored data.
- R2: For a Modified line, the home port emits kind 2 (sharing writeback) carrying the same data as the requester message, addressed to the home ID given in the intervention.
- R3: For a line in state Exclusive (encoding 2), both ports emit kind 0 (completion) with an all-zero data field.
- R4: After an intervention on a Modified or Exclusive line, the line is Shared: a repeated intervention on it yields kind 0 on both ports.
- R5: For a line in state Shared (1) or Invalid (0), both ports emit kind 0 with zero data, and the state is unchanged: a repeat again yields kind 0 on both ports.
- R6: The requester message is addressed to the requester ID taken from the intervention, and both messages echo the intervention's line address.
- R7: ivn_ready is low from the cycle after an intervention is accepted until both outgoing messages have been accepted. It is high in the cycle after the later acceptance, and it is never high while either output is valid.
- R8: Each output port holds valid and its payload stable until ready is seen. The two ports complete independently, in any order or in the same cycle.
- R9: After reset, ivn_ready is high and neither output port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ivn_valid | input | 1 | Intervention offered |
| ivn_ready | output | 1 | Responder can take an intervention |
| ivn_addr | input | ADDR_W | Line index of the intervention |
| ivn_req_id | input | NODE_W | Node that requested the line |
| ivn_home_id | input | NODE_W | Home node of the line |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload line index |
| pre_state | input | 2 | Preload state: 0 I, 1 S, 2 E, 3 M |
| pre_data | input | DATA_W | Preload line data |
| rq_valid | output | 1 | Requester message valid |
| rq_ready | input | 1 | Requester message accepted |
| rq_dest | output | NODE_W | Requester message destination |
| rq_kind | output | 2 | 0 completion, 1 data reply |
| rq_addr | output | ADDR_W | Line index |
| rq_data | output | DATA_W | Line data or zero |
| hm_valid | output | 1 | Home message valid |
| hm_ready | input | 1 | Home message accepted |
| hm_dest | output | NODE_W | Home message destination |
| hm_kind | output | 2 | 0 completion, 2 sharing writeback |
| hm_addr | output | ADDR_W | Line index |
| hm_data | output | DATA_W | Line data or zero |

## Verification
The two outgoing handshakes can finish in the same cycle or in either order. The return of ivn_ready depends on the later of the two. The bench sweeps every line and every preloaded state against ready delays of 0 to 2 cycles on each port independently. It checks that ivn_ready stays low throughout, that it rises exactly in the cycle after the later acceptance, and that both payloads match the values computed from the preloaded state and data.

// File: rtl/ivn_pkg.sv
package ivn_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {MK_DONE = 2'd0, MK_DATA = 2'd1, MK_SWB = 2'd2} msg_kind_t;
  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/ivn_line_store.sv
module ivn_line_store
  import ivn_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [1:0]        pre_state,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              dg_we,
  input  logic [ADDR_W-1:0] dg_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_state,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        st_mem  [DEPTH];
  logic [DATA_W-1:0] dat_mem [DEPTH];

  // State array: one write port, downgrade wins over preload.
  always_ff @(posedge clk) begin
    if (dg_we)       st_mem[dg_addr]  <= LS_S;
    else if (pre_we) st_mem[pre_addr] <= pre_state;
    if (rd_en)       rd_state <= st_mem[rd_addr];
  end

  // Data array: written only by preload, registered read.
  always_ff @(posedge clk) begin
    if (pre_we) dat_mem[pre_addr] <= pre_data;
    if (rd_en)  rd_data <= dat_mem[rd_addr];
  end
endmodule

// File: rtl/ivn_msg_slot.sv
module ivn_msg_slot #(
  parameter int NODE_W = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NODE_W-1:0] ld_dest,
  input  logic [1:0]        ld_kind,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_dest,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              drain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_dest <= ld_dest;
      out_kind <= ld_kind;
      out_addr <= ld_addr;
      out_data <= ld_data;
    end
  end

  // Slot will be empty after this edge.
  assign drain = !out_valid || out_ready;
endmodule

// File: rtl/ivn_ctrl.sv
module ivn_ctrl
  import ivn_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NODE_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ivn_valid,
  output logic              ivn_ready,
  input  logic [ADDR_W-1:0] ivn_addr,
  input  logic [NODE_W-1:0] ivn_req_id,
  input  logic [NODE_W-1:0] ivn_home_id,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_state,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dg_we,
  output logic [ADDR_W-1:0] dg_addr,
  output logic              slot_load,
  output logic [1:0]        kind_rq,
  output logic [1:0]        kind_hm,
  output logic [DATA_W-1:0] payload,
  output logic [NODE_W-1:0] req_q,
  output logic [NODE_W-1:0] home_q,
  output logic [ADDR_W-1:0] addr_q,
  input  logic              drain_ok
);
  typedef enum logic [1:0] {C_IDLE, C_LOOK, C_SEND} cst_t;

  cst_t     st;
  line_st_t line;
  logic     accept, dirty, owned;

  assign ivn_ready = (st == C_IDLE);
  assign accept    = ivn_valid && ivn_ready;
  assign rd_en     = accept;
  assign rd_addr   = ivn_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= C_IDLE;
    end else begin
      case (st)
        C_IDLE:  if (accept) st <= C_LOOK;
        C_LOOK:  st <= C_SEND;
        C_SEND:  if (drain_ok) st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= ivn_addr;
      req_q  <= ivn_req_id;
      home_q <= ivn_home_id;
    end
  end

  always_comb begin
    line      = line_st_t'(rd_state);
    dirty     = (line == LS_M);
    owned     = (line == LS_M) || (line == LS_E);
    slot_load = (st == C_LOOK);
    dg_we     = slot_load && owned;
    dg_addr   = addr_q;
    kind_rq   = dirty ? MK_DATA : MK_DONE;
    kind_hm   = dirty ? MK_SWB  : MK_DONE;
    payload   = dirty ? rd_data : '0;
  end
endmodule

// File: rtl/ivn_responder.sv
module ivn_responder
  import ivn_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NODE_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ivn_valid,
  output logic              ivn_ready,
  input  logic [ADDR_W-1:0] ivn_addr,
  input  logic [NODE_W-1:0] ivn_req_id,
  input  logic [NODE_W-1:0] ivn_home_id,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [1:0]        pre_state,
  input  logic [DATA_W-1:0] pre_data,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [NODE_W-1:0] rq_dest,
  output logic [1:0]        rq_kind,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [DATA_W-1:0] rq_data,
  output logic              hm_valid,
  input  logic              hm_ready,
  output logic [NODE_W-1:0] hm_dest,
  output logic [1:0]        hm_kind,
  output logic [ADDR_W-1:0] hm_addr,
  output logic [DATA_W-1:0] hm_data
);
  logic              rd_en, dg_we, slot_load;
  logic [ADDR_W-1:0] rd_addr, dg_addr, addr_q;
  logic [1:0]        rd_state, kind_rq, kind_hm;
  logic [DATA_W-1:0] rd_data, payload;
  logic [NODE_W-1:0] req_q, home_q;

  // Slot 0 goes to the requester, slot 1 to home.
  logic [NODE_W-1:0] s_ld_dest [NUM_PORTS];
  logic [1:0]        s_ld_kind [NUM_PORTS];
  logic              s_valid   [NUM_PORTS];
  logic              s_ready   [NUM_PORTS];
  logic [NODE_W-1:0] s_dest    [NUM_PORTS];
  logic [1:0]        s_kind    [NUM_PORTS];
  logic [ADDR_W-1:0] s_addr    [NUM_PORTS];
  logic [DATA_W-1:0] s_data    [NUM_PORTS];
  logic [NUM_PORTS-1:0] s_drain;

  ivn_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .pre_we(pre_we), .pre_addr(pre_addr), .pre_state(pre_state),
    .pre_data(pre_data), .dg_we(dg_we), .dg_addr(dg_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_state(rd_state), .rd_data(rd_data)
  );

  ivn_ctrl #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .ivn_valid(ivn_valid), .ivn_ready(ivn_ready),
    .ivn_addr(ivn_addr), .ivn_req_id(ivn_req_id), .ivn_home_id(ivn_home_id),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_state(rd_state), .rd_data(rd_data),
    .dg_we(dg_we), .dg_addr(dg_addr), .slot_load(slot_load),
    .kind_rq(kind_rq), .kind_hm(kind_hm), .payload(payload),
    .req_q(req_q), .home_q(home_q), .addr_q(addr_q), .drain_ok(&s_drain)
  );

  assign s_ld_dest[0] = req_q;
  assign s_ld_dest[1] = home_q;
  assign s_ld_kind[0] = kind_rq;
  assign s_ld_kind[1] = kind_hm;
  assign s_ready[0]   = rq_ready;
  assign s_ready[1]   = hm_ready;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_slot
    ivn_msg_slot #(.NODE_W(NODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .load(slot_load), .ld_dest(s_ld_dest[g]),
      .ld_kind(s_ld_kind[g]), .ld_addr(addr_q), .ld_data(payload),
      .out_valid(s_valid[g]), .out_ready(s_ready[g]), .out_dest(s_dest[g]),
      .out_kind(s_kind[g]), .out_addr(s_addr[g]), .out_data(s_data[g]),
      .drain(s_drain[g])
    );
  end

  assign rq_valid = s_valid[0];
  assign rq_dest  = s_dest[0];
  assign rq_kind  = s_kind[0];
  assign rq_addr  = s_addr[0];
  assign rq_data  = s_data[0];
  assign hm_valid = s_valid[1];
  assign hm_dest  = s_dest[1];
  assign hm_kind  = s_kind[1];
  assign hm_addr  = s_addr[1];
  assign hm_data  = s_data[1];
endmodule

// File: rtl/ivn_responder_chk.sv
module ivn_responder_chk #(
  parameter int ADDR_W = 6,
  parameter int NODE_W = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ivn_valid,
  input logic              ivn_ready,
  input logic              rq_valid,
  input logic              rq_ready,
  input logic [NODE_W-1:0] rq_dest,
  input logic [1:0]        rq_kind,
  input logic [ADDR_W-1:0] rq_addr,
  input logic [DATA_W-1:0] rq_data,
  input logic              hm_valid,
  input logic              hm_ready,
  input logic [NODE_W-1:0] hm_dest,
  input logic [1:0]        hm_kind,
  input logic [ADDR_W-1:0] hm_addr,
  input logic [DATA_W-1:0] hm_data
);
  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ivn_ready |-> (!rq_valid && !hm_valid));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ivn_valid && ivn_ready) |=> !ivn_ready);

  // R8
  rq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_data) && $stable(rq_kind)
                                 && $stable(rq_dest) && $stable(rq_addr)));

  // R8
  hm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hm_valid && !hm_ready) |=> (hm_valid && $stable(hm_data) && $stable(hm_kind)
                                 && $stable(hm_dest) && $stable(hm_addr)));

  // R2
  pair_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && hm_valid && rq_kind == 2'd1) |-> (hm_kind == 2'd2 && hm_data == rq_data));

  // R3
  rq_done_nodata_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && rq_kind == 2'd0) |-> (rq_data == '0));

  // R3
  hm_done_nodata_chk: assert property (@(posedge clk) disable iff (rst)
    (hm_valid && hm_kind == 2'd0) |-> (hm_data == '0));

  // R5
  pair_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && hm_valid) |-> ((rq_kind == 2'd0) == (hm_kind == 2'd0)));

  // R6
  pair_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && hm_valid) |-> (rq_addr == hm_addr));
endmodule

bind ivn_responder ivn_responder_chk #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ivn_valid(ivn_valid), .ivn_ready(ivn_ready),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_dest(rq_dest), .rq_kind(rq_kind),
  .rq_addr(rq_addr), .rq_data(rq_data), .hm_valid(hm_valid), .hm_ready(hm_ready),
  .hm_dest(hm_dest), .hm_kind(hm_kind), .hm_addr(hm_addr), .hm_data(hm_data)
);

// File: tb/test_ivn_responder.sv
module test_ivn_responder;
  localparam int AW = 3;
  localparam int NW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, ivn_valid, ivn_ready, pre_we;
  logic [AW-1:0] ivn_addr, pre_addr, rq_addr, hm_addr;
  logic [NW-1:0] ivn_req_id, ivn_home_id, rq_dest, hm_dest;
  logic [1:0]    pre_state, rq_kind, hm_kind;
  logic [DW-1:0] pre_data, rq_data, hm_data;
  logic          rq_valid, rq_ready, hm_valid, hm_ready;

  ivn_responder #(.ADDR_W(AW), .NODE_W(NW), .DATA_W(DW)) i_ivn_responder (
    .clk(clk), .rst(rst), .ivn_valid(ivn_valid), .ivn_ready(ivn_ready),
    .ivn_addr(ivn_addr), .ivn_req_id(ivn_req_id), .ivn_home_id(ivn_home_id),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_state(pre_state), .pre_data(pre_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_dest(rq_dest), .rq_kind(rq_kind),
    .rq_addr(rq_addr), .rq_data(rq_data), .hm_valid(hm_valid), .hm_ready(hm_ready),
    .hm_dest(hm_dest), .hm_kind(hm_kind), .hm_addr(hm_addr), .hm_data(hm_data)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // captured messages
  logic [1:0]    c_rk, c_hk;
  logic [DW-1:0] c_rd, c_hd;
  logic [NW-1:0] c_rdst, c_hdst;
  logic [AW-1:0] c_ra, c_ha;
  bit            c_busy_ok, c_ready_after, c_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_state = s; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run_ivn(input logic [AW-1:0] a, input logic [NW-1:0] rq, input logic [NW-1:0] hm,
                         input int dr, input int dh);
    bit got_r = 1'b0;
    bit got_h = 1'b0;
    int c = 0;
    c_busy_ok = 1'b1;
    @(negedge clk);
    ivn_valid = 1'b1; ivn_addr = a; ivn_req_id = rq; ivn_home_id = hm;
    @(negedge clk);
    ivn_valid = 1'b0;
    while (!(got_r && got_h) && c < 40) begin
      rq_ready = (c >= dr) && !got_r;
      hm_ready = (c >= dh) && !got_h;
      #1;
      if (ivn_ready) c_busy_ok = 1'b0;
      if (rq_valid && rq_ready) begin
        got_r = 1'b1; c_rk = rq_kind; c_rd = rq_data; c_rdst = rq_dest; c_ra = rq_addr;
      end
      if (hm_valid && hm_ready) begin
        got_h = 1'b1; c_hk = hm_kind; c_hd = hm_data; c_hdst = hm_dest; c_ha = hm_addr;
      end
      @(negedge clk);
      c++;
    end
    rq_ready = 1'b0; hm_ready = 1'b0;
    c_done = got_r && got_h;
    c_ready_after = ivn_ready && !rq_valid && !hm_valid;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ivn_valid = 1'b0; ivn_addr = '0; ivn_req_id = '0; ivn_home_id = '0;
    pre_we = 1'b0; pre_addr = '0; pre_state = '0; pre_data = '0;
    rq_ready = 1'b0; hm_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(ivn_ready == 1'b1, "R9", "ivn_ready after reset", ivn_ready, 1);
    chk(!rq_valid && !hm_valid, "R9", "valids after reset", {rq_valid, hm_valid}, 0);

    for (int ln = 0; ln < (1 << AW); ln++) begin
      for (int s = 0; s < 4; s++) begin
        for (int dr = 0; dr < 3; dr++) begin
          for (int dh = 0; dh < 3; dh++) begin
            logic [DW-1:0] d;
            logic [NW-1:0] rqid, hmid;
            logic [1:0]    ek_r, ek_h;
            logic [DW-1:0] ed;
            string         tag;
            d    = DW'(16'h1000 * s + 16'h0100 * dr + 16'h0010 * dh + ln + 1);
            rqid = NW'(ln + s + 1);
            hmid = NW'(7 - ln);
            ek_r = (s == 3) ? 2'd1 : 2'd0;
            ek_h = (s == 3) ? 2'd2 : 2'd0;
            ed   = (s == 3) ? d : '0;
            tag  = (s == 3) ? "R1" : (s == 2) ? "R3" : "R5";
            preload(AW'(ln), 2'(s), d);
            run_ivn(AW'(ln), rqid, hmid, dr, dh);
            chk(c_done, "R8", "both messages delivered", c_done, 1);
            chk(c_rk == ek_r, tag, "requester kind", c_rk, ek_r);
            chk(c_rd == ed, tag, "requester data", c_rd, ed);
            chk(c_hk == ek_h, (s == 3) ? "R2" : tag, "home kind", c_hk, ek_h);
            chk(c_hd == ed, (s == 3) ? "R2" : tag, "home data", c_hd, ed);
            chk(c_hdst == hmid, "R2", "home dest", c_hdst, hmid);
            chk(c_rdst == rqid, "R6", "requester dest", c_rdst, rqid);
            chk(c_ra == AW'(ln) && c_ha == AW'(ln), "R6", "line address", {c_ra, c_ha}, {AW'(ln), AW'(ln)});
            chk(c_busy_ok, "R7", "ivn_ready low while busy", c_busy_ok, 1);
            chk(c_ready_after, "R7", "ivn_ready after last accept", c_ready_after, 1);
            // repeat on same line: state must now be S (R4) or unchanged (R5)
            run_ivn(AW'(ln), rqid, hmid, dh, dr);
            chk(c_done, "R8", "repeat delivered", c_done, 1);
            chk(c_rk == 2'd0 && c_hk == 2'd0, (s >= 2) ? "R4" : "R5", "repeat kinds",
                {c_rk, c_hk}, 0);
            chk(c_rd == '0 && c_hd == '0, (s >= 2) ? "R4" : "R5", "repeat data",
                {c_rd, c_hd}, 0);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule